// File: doc/BRIEF.md
# Staged Rotate-Shuffle Unit

This block is the execution datapath for a generalized rotate instruction. A 32-bit operand is doubled into a 63-bit working word, whose upper copy lacks only its top bit. That word then passes through five conditional-move stages. Their strides fall from sixteen down to one. At each bit of each stage, the bit index picks which of two shift amounts governs the move. A stripe flag flips the controlling amount for part of the widest stage. This yields bit patterns that a plain barrel rotator cannot produce. With both amounts equal and stripe clear, the unit is an ordinary right rotate.

The low 32 bits of the last stage are sign-extended to the output width. They are then captured in an output register with a one-cycle valid handshake. The surrounding pipeline presents one operation per cycle on `in_valid` and takes the result one cycle later on `out_valid`. Decode and register access belong to the caller.

Top module: `rotx_unit`

## Requirements
- R1: Reset is synchronous and active high. In the cycle after a clock edge with `rst` high, `out_valid` is 0 and `result` is all zeros, even if `in_valid` was high at that edge.
- R2: `out_valid` is high in exactly the cycles that follow a clock edge at which `in_valid` was high. `result` then carries the answer for the operands sampled at that edge.
- R3: After an edge with `in_valid` low, `result` keeps its previous value. Whatever sits on `src`, `pri_amt`, `alt_amt` and `stripe` at that edge is ignored.
- R4: With `pri_amt` = 0, `alt_amt` = 0 and `stripe` = 0, `result` is the sign extension of `src`.
- R5: With `stripe` = 0 and `alt_amt` equal to `pri_amt[4:1]`, the low 32 bits of `result` are `src` rotated right by `pri_amt` places.
- R6: The working word has bit k equal to `src[k mod 32]` for k = 0..62. A stage of stride S (16, 8, 4, 2, then 1, each reading only the previous stage) replaces bit i by bit i+S for every i in 0..30+S. This happens when bit log2(S) of the chosen amount is 1; all other bits keep their value. The chosen amount is `pri_amt` when bit log2(S)-1 of i is 1, otherwise the secondary amount, whose bits 4..1 are `alt_amt`. The stride-1 stage always uses `pri_amt`. The low 32 bits of the last stage form the result.
- R7: When `stripe` is 1, in the stride-16 stage only, positions whose index bit 2 is 0 test the inverse of the chosen amount's bit 4.
- R8: `result` bits OUT_W-1..32 all equal `result[31]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on this cycle are to be processed |
| src | input | 32 | Source operand |
| pri_amt | input | 5 | Primary shift amount |
| alt_amt | input | 4 | Bits 4..1 of the secondary shift amount (bit 0 never has an effect) |
| stripe | input | 1 | Inverts the amount in the widest stage for index-bit-2-clear positions |
| out_valid | output | 1 | `result` holds a new answer |
| result | output | OUT_W (64) | Sign-extended shuffled word |

## Verification
Two pairs of events can share a cycle. The first is a new operand being captured while the previous answer is on the output. The stimulus drives long back-to-back runs of random operands, and a scoreboard pairs each answer with the operation that produced it. Gaps with changing operands are inserted between runs to show that the held value is undisturbed. The second is reset meeting an asserted `in_valid`: the run ends by raising reset in the cycle after a valid operand, and the output must be cleared rather than loaded.

// File: rtl/rotx_pkg.sv
package rotx_pkg;
  // Operand width; the stage strides below are tied to this value.
  parameter int SRC_W   = 32;
  parameter int AMT_W   = 5;
  parameter int NSTAGE  = 5;
  // Doubled word: bit 63 of a full double is never read by any stage.
  parameter int WORK_W  = 2 * SRC_W - 1;
endpackage

// File: rtl/rotx_stage.sv
module rotx_stage #(
  parameter int SRC_W  = 32,
  parameter int STRIDE = 16
) (
  input  logic [SRC_W+2*STRIDE-2:0] d_in,
  input  logic                      pri_bit,
  input  logic                      alt_bit,
  input  logic                      invert_lo,
  output logic [SRC_W+STRIDE-2:0]   d_out
);
  // Index bit that steers between the two amounts.
  localparam int SEL_BIT = (STRIDE > 1) ? $clog2(STRIDE) - 1 : 0;
  localparam int OUT_N   = SRC_W + STRIDE - 1;

  for (genvar b = 0; b < OUT_N; b++) begin : g_bit
    localparam bit USE_PRI = ((b >> SEL_BIT) & 1) == 1;
    localparam bit LO_GRP  = ((b >> 2) & 1) == 0;
    logic raw, gate;
    assign raw   = USE_PRI ? pri_bit : alt_bit;
    assign gate  = (LO_GRP && invert_lo) ? ~raw : raw;
    assign d_out[b] = gate ? d_in[b+STRIDE] : d_in[b];
  end
endmodule

// File: rtl/rotx_core.sv
module rotx_core
  import rotx_pkg::*;
(
  input  logic [SRC_W-1:0] src,
  input  logic [AMT_W-1:0] pri_amt,
  input  logic [AMT_W-1:1] alt_amt,
  input  logic             stripe,
  output logic [SRC_W-1:0] low_word
);
  logic [WORK_W-1:0] doubled;
  assign doubled = {src[SRC_W-2:0], src};

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    localparam int STRIDE = 1 << (NSTAGE - 1 - k);
    localparam int GATE   = NSTAGE - 1 - k;
    logic [SRC_W+2*STRIDE-2:0] s_in;
    logic [SRC_W+STRIDE-2:0]   s_out;
    logic                      a_bit;
    logic                      inv;

    if (k == 0) begin : g_first
      assign s_in = doubled;
      assign inv  = stripe;
    end else begin : g_next
      assign s_in = g_stage[k-1].s_out;
      assign inv  = 1'b0;
    end

    if (STRIDE > 1) begin : g_alt
      assign a_bit = alt_amt[GATE];
    end else begin : g_pri_only
      assign a_bit = pri_amt[0];
    end

    rotx_stage #(.SRC_W(SRC_W), .STRIDE(STRIDE)) u_stage (
      .d_in      (s_in),
      .pri_bit   (pri_amt[GATE]),
      .alt_bit   (a_bit),
      .invert_lo (inv),
      .d_out     (s_out)
    );
  end

  assign low_word = g_stage[NSTAGE-1].s_out;
endmodule

// File: rtl/rotx_outreg.sv
module rotx_outreg #(
  parameter int SRC_W   = 32,
  parameter int OUT_W   = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [SRC_W-1:0] low_word,
  output logic             out_valid,
  output logic [OUT_W-1:0] result
);
  logic [OUT_W-1:0] ext;

  if (OUT_W > SRC_W) begin : g_ext
    assign ext = {{(OUT_W-SRC_W){low_word[SRC_W-1]}}, low_word};
  end else begin : g_same
    assign ext = low_word;
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid <= 1'b0;
        result    <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) result <= ext;
      end
    end
  end else begin : g_comb
    assign out_valid = in_valid;
    assign result    = ext;
  end
endmodule

// File: rtl/rotx_unit.sv
module rotx_unit
  import rotx_pkg::*;
#(
  parameter int OUT_W   = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [31:0]      src,
  input  logic [4:0]       pri_amt,
  input  logic [4:1]       alt_amt,
  input  logic             stripe,
  output logic             out_valid,
  output logic [OUT_W-1:0] result
);
  logic [SRC_W-1:0] low_word;

  rotx_core u_core (
    .src      (src),
    .pri_amt  (pri_amt),
    .alt_amt  (alt_amt),
    .stripe   (stripe),
    .low_word (low_word)
  );

  rotx_outreg #(.SRC_W(SRC_W), .OUT_W(OUT_W), .REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .low_word  (low_word),
    .out_valid (out_valid),
    .result    (result)
  );
endmodule

// File: rtl/rotx_unit_chk.sv
module rotx_unit_chk #(
  parameter int OUT_W   = 64,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [31:0]      src,
  input logic [4:0]       pri_amt,
  input logic [4:1]       alt_amt,
  input logic             stripe,
  input logic             out_valid,
  input logic [OUT_W-1:0] result
);
  function automatic logic [31:0] rot_right(input logic [31:0] v, input logic [4:0] n);
    logic [63:0] w;
    w = {v, v} >> n;
    return w[31:0];
  endfunction

  if (REG_OUT) begin : g_reg
    assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (!out_valid && result == '0));

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(result));

    assert_identity_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && pri_amt == 5'd0 && alt_amt == 4'd0 && !stripe)
      |=> (result[31:0] == $past(src)));

    assert_plain_rotate_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !stripe && alt_amt == pri_amt[4:1])
      |=> (result[31:0] == rot_right($past(src), $past(pri_amt))));

    if (OUT_W > 32) begin : g_ext
      assert_sign_ext_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (result[OUT_W-1:32] == {(OUT_W-32){result[31]}}));
    end
  end
endmodule

bind rotx_unit rotx_unit_chk #(.OUT_W(OUT_W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/test_rotx_unit.sv
`timescale 1ns/1ps
module test_rotx_unit;
  localparam int OUT_W = 64;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [31:0]      src = '0;
  logic [4:0]       pri_amt = '0;
  logic [4:1]       alt_amt = '0;
  logic             stripe = 1'b0;
  logic             out_valid;
  logic [OUT_W-1:0] result;

  rotx_unit #(.OUT_W(OUT_W), .REG_OUT(1'b1)) i_rotx_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src(src),
    .pri_amt(pri_amt), .alt_amt(alt_amt), .stripe(stripe),
    .out_valid(out_valid), .result(result)
  );

  always #10 clk = ~clk;

  int              n_checks = 0;
  int              n_errors = 0;
  bit              mon_en   = 1'b0;
  bit              finished = 1'b0;
  logic [63:0]     held     = '0;
  logic [63:0]     exp_q[$];
  string           tag_q[$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] sext(input logic [31:0] x);
    return {{32{x[31]}}, x};
  endfunction

  // Staged shuffle as written in R6/R7.
  function automatic logic [31:0] model(input logic [31:0] s, input logic [4:0] sh,
                                        input logic [4:0] sx, input bit st);
    logic [63:0] a, b;
    logic [4:0]  amt;
    a = {s, s};
    for (int k = 0; k < 5; k++) begin
      int str;
      str = 16 >> k;
      b = a;
      for (int i = 0; i <= 30 + str; i++) begin
        if (str == 1) amt = sh;
        else amt = ((i & (str >> 1)) != 0) ? sh : sx;
        if (k == 0 && st && (i & 4) == 0) amt = ~amt;
        if ((amt & str[4:0]) != 0) b[i] = a[i+str];
      end
      a = b;
    end
    return a[31:0];
  endfunction

  function automatic logic [31:0] rotr(input logic [31:0] v, input logic [4:0] n);
    logic [63:0] w;
    w = {v, v} >> n;
    return w[31:0];
  endfunction

  task automatic send(input logic [31:0] s, input logic [4:0] sh, input logic [4:0] sx,
                      input bit st, input logic [31:0] exp32, input string tag);
    @(posedge clk); #1;
    in_valid = 1'b1; src = s; pri_amt = sh; alt_amt = sx[4:1]; stripe = st;
    exp_q.push_back(sext(exp32));
    tag_q.push_back(tag);
  endtask

  task automatic gap(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      in_valid = 1'b0; src = $urandom; pri_amt = 5'($urandom);
      alt_amt = 4'($urandom); stripe = 1'($urandom);
    end
  endtask

  // Monitor: pops the scoreboard whenever an answer appears.
  always @(negedge clk) begin
    if (mon_en) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 out_valid with no pending operation", {63'd0, out_valid}, 64'd0);
        end else begin
          logic [63:0] e;
          string       t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(result == e, t, result, e);
          check(result[63:32] == {32{result[31]}}, "R8 sign extension", result, sext(result[31:0]));
        end
      end else begin
        check(result == held, "R3 result held while idle", result, held);
      end
      held = result;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_checks++;
    n_errors++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [4:0]  a, b;
    bit          st;

    // R1: reset with in_valid asserted.
    in_valid = 1'b1; src = 32'hDEAD_BEEF;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check(!out_valid, "R1 out_valid low in reset", {63'd0, out_valid}, 64'd0);
    check(result == '0, "R1 result cleared in reset", result, 64'd0);
    @(posedge clk); #1;
    rst = 1'b0; in_valid = 1'b0;
    held = '0; mon_en = 1'b1;

    // R4: identity.
    send(32'h0000_0000, 5'd0, 5'd0, 1'b0, 32'h0000_0000, "R4 identity zero");
    send(32'hFFFF_FFFF, 5'd0, 5'd0, 1'b0, 32'hFFFF_FFFF, "R4 identity ones");
    send(32'h8000_0000, 5'd0, 5'd0, 1'b0, 32'h8000_0000, "R4 identity msb");
    send(32'h1234_5678, 5'd0, 5'd0, 1'b0, 32'h1234_5678, "R4 identity pattern");
    send(32'h7FFF_FFFF, 5'd0, 5'd0, 1'b0, 32'h7FFF_FFFF, "R4 identity positive");
    gap(2);

    // R5: equal amounts give a plain rotate; every amount.
    for (int n = 0; n < 32; n++) begin
      r = $urandom;
      send(r, 5'(n), 5'(n), 1'b0, rotr(r, 5'(n)), "R5 plain rotate");
    end
    send(32'h0000_0001, 5'd1, 5'd1, 1'b0, 32'h8000_0000, "R5 rotate lsb to msb");
    send(32'h8000_0000, 5'd31, 5'd31, 1'b0, 32'h0000_0001, "R5 rotate by 31");
    gap(3);

    // R7: stripe mode, directed then random.
    send(32'h1234_5678, 5'd0, 5'd0, 1'b1, model(32'h1234_5678, 5'd0, 5'd0, 1'b1), "R7 stripe zero amounts");
    send(32'hA5A5_0F0F, 5'd16, 5'd16, 1'b1, model(32'hA5A5_0F0F, 5'd16, 5'd16, 1'b1), "R7 stripe amount 16");
    send(32'hFFFF_0000, 5'd31, 5'd3, 1'b1, model(32'hFFFF_0000, 5'd31, 5'd3, 1'b1), "R7 stripe mixed");
    for (int n = 0; n < 40; n++) begin
      r = $urandom; a = 5'($urandom); b = 5'($urandom);
      send(r, a, b, 1'b1, model(r, a, b, 1'b1), "R7 stripe random");
    end
    gap(1);

    // R6: unequal amounts, with and without stripe, bursts and gaps.
    send(32'hCAFE_F00D, 5'd8, 5'd0, 1'b0, model(32'hCAFE_F00D, 5'd8, 5'd0, 1'b0), "R6 split amounts");
    send(32'h0F0F_F0F0, 5'd1, 5'd30, 1'b0, model(32'h0F0F_F0F0, 5'd1, 5'd30, 1'b0), "R6 odd primary");
    for (int n = 0; n < 300; n++) begin
      r = $urandom; a = 5'($urandom); b = 5'($urandom); st = 1'($urandom);
      send(r, a, b, st, model(r, a, b, st), "R6 random mix");
      if (($urandom % 7) == 0) gap(1 + ($urandom % 3));
    end

    // R1: reset rising right after a valid operand, with in_valid held high.
    send(32'h8765_4321, 5'd5, 5'd9, 1'b0, model(32'h8765_4321, 5'd5, 5'd9, 1'b0), "R6 before reset");
    @(posedge clk);
    @(negedge clk); #1;
    mon_en = 1'b0; rst = 1'b1; in_valid = 1'b1; src = 32'hFFFF_FFFF;
    @(negedge clk); #1;
    check(!out_valid, "R1 reset overrides in_valid", {63'd0, out_valid}, 64'd0);
    check(result == '0, "R1 reset clears result", result, 64'd0);
    check(exp_q.size() == 0, "R2 every operation answered", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule